// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checks

The block holds recently used page translations in a small fully associative array. In every cycle a requester presents a virtual page number, the current address space identifier, an access kind (read, write or execute) and a user/kernel flag. Within the same cycle the block returns a hit flag, the physical frame number of the matching entry and a violation code. The violation code either confirms a legal access or gives the reason it was refused. A refused access can be a missing translation, a user access to a kernel-only page, or a read, write or execute the entry does not permit.

Every entry is tagged with an address space identifier. Translations that belong to different processes can therefore stay resident together, and a context switch does not have to empty the array. Software maintains the contents through one operation port that has four commands: refill, single-entry invalidate, flush and no-op. A refill can mark its entry as locked, and the replacement pointer never picks a locked entry. This is how the kernel mapping stays resident. Page table walks and miss handling are the requester's job; the block only reports a miss.

Top module: `tlb_fa`

## Requirements
- R1: When a valid entry has the same page number and identifier as the request, `hit_o` is 1 and `pfn_o` carries that entry's frame number in the same cycle.
- R2: An entry whose identifier differs from `asid_i` never matches, even if its page number is equal.
- R3: On a hit with `user_i`=1 against an entry marked kernel-only, `viol_o` is 2. This check takes precedence over the right checks.
- R4: On a hit that passes R3, `viol_o` is 3 when `acc_i`=1 (write) and the entry lacks write permission. It is 5 when `acc_i`=2 (execute) and the entry lacks execute permission. It is 4 when `acc_i` is 0 or 3 (read) and the entry lacks read permission. In every other case it is 0.
- R5: On a miss, `hit_o` is 0, `pfn_o` is 0 and `viol_o` is 1.
- R6: A refill (`op_i`=1) with no existing match is written to the first unlocked entry found by scanning circularly from a round-robin pointer. The pointer starts at entry 0 after reset and moves to the entry after the one written. Locked entries are never chosen.
- R7: A refill whose page number and identifier already match a valid entry overwrites that entry in place and does not move the pointer.
- R8: An invalidate (`op_i`=2) clears the valid and lock bits of the entry that matches `fill_vpn_i`/`fill_asid_i`. Other entries are unaffected.
- R9: A flush (`op_i`=3) clears every unlocked entry. Locked entries stay valid.
- R10: After reset, no entry is valid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vpn_i | input | VPN_W | Lookup virtual page number |
| asid_i | input | ASID_W | Lookup address space identifier |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| hit_o | output | 1 | A matching valid entry exists |
| pfn_o | output | PFN_W | Frame number of the match, 0 on miss |
| viol_o | output | 3 | 0 ok, 1 miss, 2 privilege, 3 write, 4 read, 5 execute |
| op_i | input | 2 | 0 none, 1 refill, 2 invalidate, 3 flush |
| fill_vpn_i | input | VPN_W | Page number for refill or invalidate |
| fill_asid_i | input | ASID_W | Identifier for refill or invalidate |
| fill_pfn_i | input | PFN_W | Frame number for refill |
| fill_kern_i | input | 1 | Refill entry is kernel-only |
| fill_rd_i | input | 1 | Refill entry allows read |
| fill_wr_i | input | 1 | Refill entry allows write |
| fill_ex_i | input | 1 | Refill entry allows execute |
| fill_lock_i | input | 1 | Refill entry is locked against replacement |

## Verification
The hardest case to reach is a replacement pointer that wraps past a locked entry. The only way there from the ports is to fill every other slot first. The stimulus refills a locked kernel mapping and then issues one more distinct refill than there are entries. It then checks three things: the oldest unlocked translation was evicted, the next oldest is still present, and the locked mapping still hits. It also checks that this locked mapping survives a flush and goes away only on an explicit invalidate.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {OP_NOP, OP_FILL, OP_INVAL, OP_FLUSH} op_e;
  typedef enum logic [1:0] {ACC_RD, ACC_WR, ACC_EX, ACC_RSV} acc_e;
  typedef enum logic [2:0] {V_NONE, V_MISS, V_PRIV, V_WRITE, V_READ, V_EXEC} viol_e;
  typedef struct packed {
    logic kern;
    logic rd;
    logic wr;
    logic ex;
  } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   tag_vpn_i  [ENTRIES],
  input  logic [ASID_W-1:0]  tag_asid_i [ENTRIES],
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [ASID_W-1:0]  asid_i,
  output logic [ENTRIES-1:0] match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_vpn_i[g] == vpn_i) && (tag_asid_i[g] == asid_i);
  end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins if software created duplicates
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [IDX_W-1:0]   ptr_i,
  input  logic [ENTRIES-1:0] lock_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= ENTRIES) j = j - ENTRIES;
      if (!found_o && !lock_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  output logic              hit_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [2:0]        viol_o,
  input  logic [1:0]        op_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_kern_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_ex_i,
  input  logic              fill_lock_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, lock_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fm_match;
  logic               lk_hit, fm_hit, vic_found;
  logic [IDX_W-1:0]   lk_idx, fm_idx, vic_idx, wr_idx;
  logic               wr_en;
  perm_t              lk_perm;
  op_e                op;

  assign op = op_e'(op_i);

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid_i(valid_q), .tag_vpn_i(vpn_q), .tag_asid_i(asid_q),
    .vpn_i(vpn_i), .asid_i(asid_i), .match_o(lk_match));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fm_match (
    .valid_i(valid_q), .tag_vpn_i(vpn_q), .tag_asid_i(asid_q),
    .vpn_i(fill_vpn_i), .asid_i(fill_asid_i), .match_o(fm_match));

  tlb_first #(.ENTRIES(ENTRIES)) u_lk_first (.match_i(lk_match), .hit_o(lk_hit), .idx_o(lk_idx));
  tlb_first #(.ENTRIES(ENTRIES)) u_fm_first (.match_i(fm_match), .hit_o(fm_hit), .idx_o(fm_idx));

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .ptr_i(ptr_q), .lock_i(lock_q), .found_o(vic_found), .idx_o(vic_idx));

  // lookup path
  assign lk_perm = perm_q[lk_idx];
  assign hit_o   = lk_hit;
  assign pfn_o   = lk_hit ? pfn_q[lk_idx] : '0;

  always_comb begin
    viol_e v;
    if (!lk_hit)                      v = V_MISS;
    else if (user_i && lk_perm.kern)  v = V_PRIV;
    else begin
      unique case (acc_e'(acc_i))
        ACC_WR:  v = lk_perm.wr ? V_NONE : V_WRITE;
        ACC_EX:  v = lk_perm.ex ? V_NONE : V_EXEC;
        default: v = lk_perm.rd ? V_NONE : V_READ;
      endcase
    end
    viol_o = v;
  end

  // refill target: existing match first, else round-robin victim
  assign wr_en  = (op == OP_FILL) && (fm_hit || vic_found);
  assign wr_idx = fm_hit ? fm_idx : vic_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (op)
        OP_FILL: if (wr_en) begin
          valid_q[wr_idx] <= 1'b1;
          lock_q[wr_idx]  <= fill_lock_i;
          if (!fm_hit)
            ptr_q <= (vic_idx == IDX_W'(ENTRIES - 1)) ? '0 : vic_idx + 1'b1;
        end
        OP_INVAL: if (fm_hit) begin
          valid_q[fm_idx] <= 1'b0;
          lock_q[fm_idx]  <= 1'b0;
        end
        OP_FLUSH: valid_q <= valid_q & lock_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= fill_vpn_i;
      asid_q[wr_idx] <= fill_asid_i;
      pfn_q[wr_idx]  <= fill_pfn_i;
      perm_q[wr_idx] <= '{kern: fill_kern_i, rd: fill_rd_i, wr: fill_wr_i, ex: fill_ex_i};
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int PFN_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         op_i,
  input logic [1:0]         acc_i,
  input logic               user_i,
  input logic               hit_o,
  input logic [PFN_W-1:0]   pfn_o,
  input logic [2:0]         viol_o,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lock_q
);
  // R5
  miss_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (viol_o == 3'(V_MISS) && pfn_o == '0));

  // R1
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_q != '0));

  // R3
  priv_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o == 3'(V_PRIV)) |-> (user_i && hit_o));

  // R4
  write_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o == 3'(V_WRITE)) |-> (acc_i == 2'(ACC_WR)));

  // R4
  exec_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o == 3'(V_EXEC)) |-> (acc_i == 2'(ACC_EX)));

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) == 2'(OP_FLUSH)) |-> ((valid_q & ~lock_q) == '0));

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) != 2'(OP_INVAL)) |-> (($past(lock_q) & ~lock_q) == '0));
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
  localparam int CLK_PERIOD = 10;
  localparam int N = 48;

  typedef struct {
    logic        hit;
    logic [15:0] pfn;
    logic [2:0]  viol;
    string       tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [19:0] vpn_i = '0, fill_vpn_i = '0;
  logic [7:0]  asid_i = '0, fill_asid_i = '0;
  logic [1:0]  acc_i = '0, op_i = '0;
  logic        user_i = 1'b0;
  logic        hit_o;
  logic [15:0] pfn_o, fill_pfn_i = '0;
  logic [2:0]  viol_o;
  logic fill_kern_i = 0, fill_rd_i = 0, fill_wr_i = 0, fill_ex_i = 0, fill_lock_i = 0;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_fa #(.ENTRIES(N), .VPN_W(20), .ASID_W(8), .PFN_W(16)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .vpn_i(vpn_i), .asid_i(asid_i), .acc_i(acc_i),
    .user_i(user_i), .hit_o(hit_o), .pfn_o(pfn_o), .viol_o(viol_o), .op_i(op_i),
    .fill_vpn_i(fill_vpn_i), .fill_asid_i(fill_asid_i), .fill_pfn_i(fill_pfn_i),
    .fill_kern_i(fill_kern_i), .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i),
    .fill_ex_i(fill_ex_i), .fill_lock_i(fill_lock_i));

  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                      input logic usr, input logic eh, input logic [15:0] ep,
                      input logic [2:0] ev, input string tag);
    @(negedge clk_i);
    op_i = 2'd0; vpn_i = v; asid_i = a; acc_i = acc; user_i = usr;
    q.push_back('{hit: eh, pfn: ep, viol: ev, tag: tag});
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [15:0] p,
                      input logic k, input logic r, input logic w, input logic x,
                      input logic lk);
    @(negedge clk_i);
    op_i = 2'd1; fill_vpn_i = v; fill_asid_i = a; fill_pfn_i = p;
    fill_kern_i = k; fill_rd_i = r; fill_wr_i = w; fill_ex_i = x; fill_lock_i = lk;
  endtask

  task automatic inval(input logic [19:0] v, input logic [7:0] a);
    @(negedge clk_i);
    op_i = 2'd2; fill_vpn_i = v; fill_asid_i = a;
  endtask

  task automatic flush();
    @(negedge clk_i);
    op_i = 2'd3;
  endtask

  task automatic idle();
    @(negedge clk_i);
    op_i = 2'd0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (hit_o !== e.hit || pfn_o !== e.pfn || viol_o !== e.viol) begin
          n_bad++;
          $display("FAIL %s: hit=%0b/%0b pfn=%h/%h viol=%0d/%0d (actual/expected)",
                   e.tag, hit_o, e.hit, pfn_o, e.pfn, viol_o, e.viol);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;

    look(20'h5, 8'd1, 2'd0, 1'b0, 0, 16'h0, 3'd1, "R10 empty after reset");

    fill(20'h100, 8'd1, 16'h00A1, 0, 1, 1, 1, 0);                // entry 0
    look(20'h100, 8'd1, 2'd0, 1'b1, 1, 16'h00A1, 3'd0, "R1 user read hit");
    look(20'h100, 8'd2, 2'd0, 1'b1, 0, 16'h0, 3'd1, "R2 other asid misses");
    look(20'h101, 8'd1, 2'd1, 1'b0, 0, 16'h0, 3'd1, "R5 miss code");

    fill(20'h200, 8'd1, 16'h00B2, 1, 1, 0, 0, 0);                // entry 1, kernel r only
    look(20'h200, 8'd1, 2'd1, 1'b1, 1, 16'h00B2, 3'd2, "R3 user to kernel page");
    look(20'h200, 8'd1, 2'd0, 1'b0, 1, 16'h00B2, 3'd0, "R4 kernel read ok");
    look(20'h200, 8'd1, 2'd1, 1'b0, 1, 16'h00B2, 3'd3, "R4 write denied");
    look(20'h200, 8'd1, 2'd2, 1'b0, 1, 16'h00B2, 3'd5, "R4 exec denied");

    fill(20'h300, 8'd1, 16'h00C3, 0, 0, 1, 1, 0);                // entry 2, no read
    look(20'h300, 8'd1, 2'd0, 1'b1, 1, 16'h00C3, 3'd4, "R4 read denied");
    look(20'h300, 8'd1, 2'd3, 1'b1, 1, 16'h00C3, 3'd4, "R4 code 3 acts as read");
    look(20'h300, 8'd1, 2'd1, 1'b1, 1, 16'h00C3, 3'd0, "R4 write allowed");

    fill(20'h100, 8'd1, 16'h00D4, 0, 1, 1, 1, 0);                // overwrite entry 0
    look(20'h100, 8'd1, 2'd0, 1'b1, 1, 16'h00D4, 3'd0, "R7 overwrite in place");

    inval(20'h200, 8'd1);
    look(20'h200, 8'd1, 2'd0, 1'b0, 0, 16'h0, 3'd1, "R8 invalidated entry misses");
    look(20'h300, 8'd1, 2'd1, 1'b0, 1, 16'h00C3, 3'd0, "R8 neighbour kept");

    flush();
    look(20'h100, 8'd1, 2'd0, 1'b0, 0, 16'h0, 3'd1, "R9 flush clears unlocked");

    // pointer at 3: locked kernel entry lands there
    fill(20'hFFFFF, 8'd0, 16'h00FF, 1, 1, 1, 1, 1);
    for (int i = 0; i < N; i++)
      fill(20'h1000 + 20'(i), 8'd1, 16'h0100 + 16'(i), 0, 1, 1, 0, 0);
    look(20'h1000, 8'd1, 2'd0, 1'b1, 0, 16'h0, 3'd1, "R6 oldest evicted after wrap");
    look(20'h1001, 8'd1, 2'd0, 1'b1, 1, 16'h0101, 3'd0, "R6 next oldest kept");
    look(20'h102F, 8'd1, 2'd0, 1'b1, 1, 16'h012F, 3'd0, "R6 last refill present");
    look(20'hFFFFF, 8'd0, 2'd2, 1'b0, 1, 16'h00FF, 3'd0, "R6 locked entry skipped");

    flush();
    look(20'hFFFFF, 8'd0, 2'd0, 1'b0, 1, 16'h00FF, 3'd0, "R9 locked survives flush");
    look(20'h1001, 8'd1, 2'd0, 1'b1, 0, 16'h0, 3'd1, "R9 unlocked gone");

    inval(20'hFFFFF, 8'd0);
    look(20'hFFFFF, 8'd0, 2'd0, 1'b0, 0, 16'h0, 3'd1, "R8 locked entry invalidated");

    idle();
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule